// File: doc/BRIEF.md
# Static Conditional Branch Predictor

This block gives a fixed direction guess for each conditional branch in a simple in-order core, and it accounts for the cycles each branch costs. When a branch is issued, the block reads two things: the sign of the branch displacement and a forward-prediction enable bit in a control word. From these it registers a predicted-taken flag. Later, the execute stage reports the real outcome. The block compares the outcome with the guess and reports the branch cost: one cycle on a correct guess and five on a wrong one. On a wrong guess it also sends a single-cycle redirect request to the fetch logic.

During the penalty window after a wrong guess, and while a branch waits for its outcome, the block holds a busy flag. Branch requests that arrive while busy is high are dropped. Target address calculation, condition evaluation and the pipeline itself belong to other blocks. The resolved-outcome inputs stand in for the execute stage.

Top module: `static_branch_pred`

## Requirements
- R1: A branch whose displacement sign bit (MSB of `disp_i`) is 1, which is a backward branch, is predicted taken whatever the control word holds.
- R2: A forward branch is predicted taken when bit 7 of `ctrl_i` is 1.
- R3: A forward branch is predicted not taken when bit 7 of `ctrl_i` is 0.
- R4: A displacement of zero counts as forward.
- R5: A request is accepted on a clock edge where `br_valid_i` is 1 and `busy_o` is 0. In the next cycle `pred_valid_o` is 1 for exactly one cycle. `pred_taken_o` shows the prediction and keeps it until the next accepted request.
- R6: While a branch is pending, a clock edge with `res_valid_i` set resolves it. If `res_taken_i` equals the prediction, the next cycle shows `done_o`=1, `cost_o`=1 and `redirect_o`=0, and `busy_o` is 0.
- R7: If the outcome differs from the prediction, the next cycle shows `done_o`=1, `redirect_o`=1 and `cost_o`=5. `redirect_o` lasts a single cycle.
- R8: After a misprediction, `busy_o` stays 1 for 4 cycles, starting in the redirect cycle, and then falls to 0.
- R9: `br_valid_i` is ignored while `busy_o` is 1. No `pred_valid_o` follows, and `pred_taken_o` does not change.
- R10: After reset, `busy_o`, `pred_valid_o`, `pred_taken_o`, `done_o`, `redirect_o` and `cost_o` are all 0.
- R11: `res_valid_i` is ignored when no branch is pending, so no `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch request strobe |
| disp_i | input | DISP_W | Signed branch displacement |
| ctrl_i | input | CTRL_W | Control word; bit FWD_EN_BIT enables the forward-taken guess |
| res_valid_i | input | 1 | Outcome strobe from execute |
| res_taken_i | input | 1 | Real branch direction |
| busy_o | output | 1 | Branch pending or penalty stall |
| pred_valid_o | output | 1 | One-cycle strobe: prediction ready |
| pred_taken_o | output | 1 | Predicted direction |
| done_o | output | 1 | One-cycle strobe: branch resolved |
| redirect_o | output | 1 | One-cycle fetch redirect on misprediction |
| cost_o | output | CNT_W | Cycles charged to the last resolved branch |

## Verification
The bench runs every combination of displacement class (negative, zero, positive), enable bit and actual outcome. This sweep exposes a predictor that treats zero as backward, since zero with the enable bit off would then wrongly show taken. It also exposes a predictor that lets the enable bit gate backward branches, which would lose the taken guess on loops. The bench counts busy cycles after each miss and fires requests into the pending and stall windows. A penalty counter that is off by one would show up as a wrong busy length, and a weak busy gate would show up as a spurious `pred_valid_o` or a changed prediction. Outcome strobes sent while idle catch a block that reports a branch it never accepted.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } sbp_state_e;
endpackage

// File: rtl/sbp_dir.sv
module sbp_dir #(
  parameter int DISP_W     = 16,
  parameter int CTRL_W     = 8,
  parameter int FWD_EN_BIT = 7
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              taken_o
);
  logic backward;
  assign backward = disp_i[DISP_W-1];   // zero has sign 0 -> forward
  assign taken_o  = backward | ctrl_i[FWD_EN_BIT];
endmodule

// File: rtl/sbp_stall.sv
module sbp_stall #(
  parameter int MISS_COST = 5,
  parameter int CNT_W     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(MISS_COST - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/static_branch_pred.sv
module static_branch_pred
  import sbp_pkg::*;
#(
  parameter int DISP_W     = 16,
  parameter int CTRL_W     = 8,
  parameter int FWD_EN_BIT = 7,
  parameter int HIT_COST   = 1,
  parameter int MISS_COST  = 5,
  localparam int CNT_W     = $clog2(MISS_COST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  output logic              busy_o,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              done_o,
  output logic              redirect_o,
  output logic [CNT_W-1:0]  cost_o
);
  sbp_state_e st_q;
  logic       dir_taken;
  logic       stall_active;
  logic       accept;
  logic       resolve;
  logic       miss;

  sbp_dir #(
    .DISP_W    (DISP_W),
    .CTRL_W    (CTRL_W),
    .FWD_EN_BIT(FWD_EN_BIT)
  ) u_dir (
    .disp_i (disp_i),
    .ctrl_i (ctrl_i),
    .taken_o(dir_taken)
  );

  assign busy_o  = (st_q == ST_WAIT) | stall_active;
  assign accept  = br_valid_i & ~busy_o;
  assign resolve = (st_q == ST_WAIT) & res_valid_i;
  assign miss    = resolve & (res_taken_i != pred_taken_o);

  sbp_stall #(
    .MISS_COST(MISS_COST),
    .CNT_W    (CNT_W)
  ) u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (miss),
    .active_o(stall_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
      done_o       <= 1'b0;
      redirect_o   <= 1'b0;
      cost_o       <= '0;
    end else begin
      pred_valid_o <= 1'b0;
      done_o       <= 1'b0;
      redirect_o   <= 1'b0;
      if (accept) begin
        st_q         <= ST_WAIT;
        pred_valid_o <= 1'b1;
        pred_taken_o <= dir_taken;
      end else if (resolve) begin
        st_q       <= ST_IDLE;
        done_o     <= 1'b1;
        redirect_o <= miss;
        cost_o     <= miss ? CNT_W'(MISS_COST) : CNT_W'(HIT_COST);
      end
    end
  end
endmodule

// File: rtl/sbp_chk.sv
module sbp_chk #(
  parameter int DISP_W    = 16,
  parameter int HIT_COST  = 1,
  parameter int MISS_COST = 5,
  parameter int CNT_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              br_valid_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              busy_o,
  input logic              pred_valid_o,
  input logic              pred_taken_o,
  input logic              done_o,
  input logic              redirect_o,
  input logic [CNT_W-1:0]  cost_o
);
  // R1
  backward_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !busy_o && disp_i[DISP_W-1]) |=> (pred_valid_o && pred_taken_o));

  // R5
  accept_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !busy_o) |=> pred_valid_o);

  // R5
  pred_valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |=> !pred_valid_o);

  // R6
  hit_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !redirect_o) |-> (cost_o == CNT_W'(HIT_COST)));

  // R7
  miss_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (done_o && cost_o == CNT_W'(MISS_COST)));

  // R7
  redirect_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  // R8
  redirect_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> busy_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pred_valid_o) |=> $stable(pred_taken_o));
endmodule

bind static_branch_pred sbp_chk #(
  .DISP_W   (DISP_W),
  .HIT_COST (HIT_COST),
  .MISS_COST(MISS_COST),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_valid_i  (br_valid_i),
  .disp_i      (disp_i),
  .busy_o      (busy_o),
  .pred_valid_o(pred_valid_o),
  .pred_taken_o(pred_taken_o),
  .done_o      (done_o),
  .redirect_o  (redirect_o),
  .cost_o      (cost_o)
);

// File: tb/sim_static_branch_pred.sv
`timescale 1ns/1ps
module sim_static_branch_pred;
  localparam int DISP_W = 16;
  localparam int CTRL_W = 8;
  localparam int CNT_W  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              br_valid_i = 1'b0;
  logic [DISP_W-1:0] disp_i = '0;
  logic [CTRL_W-1:0] ctrl_i = '0;
  logic              res_valid_i = 1'b0;
  logic              res_taken_i = 1'b0;
  logic              busy_o, pred_valid_o, pred_taken_o, done_o, redirect_o;
  logic [CNT_W-1:0]  cost_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  static_branch_pred u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .br_valid_i(br_valid_i), .disp_i(disp_i),
    .ctrl_i(ctrl_i), .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .busy_o(busy_o), .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
    .done_o(done_o), .redirect_o(redirect_o), .cost_o(cost_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_branch(input int dclass, input bit en, input bit taken);
    bit exp_pred, mis;
    logic [DISP_W-1:0] d;
    d = (dclass == 0) ? DISP_W'(-12) : (dclass == 1) ? '0 : DISP_W'(40);
    exp_pred = (dclass == 0) || en;   // R1 R2 R3 R4
    mis = (exp_pred != taken);
    @(negedge clk_i);
    br_valid_i = 1'b1; disp_i = d; ctrl_i = en ? 8'h80 : 8'h7F;
    @(negedge clk_i);
    // try a conflicting request while pending
    disp_i = (dclass == 0) ? DISP_W'(8) : DISP_W'(-8);
    ctrl_i = en ? 8'h00 : 8'hFF;
    chk("R5 pred_valid", pred_valid_o, 1);
    if (dclass == 0)      chk("R1 backward taken", pred_taken_o, exp_pred);
    else if (dclass == 1) chk("R4 zero forward", pred_taken_o, exp_pred);
    else if (en)          chk("R2 forward enabled", pred_taken_o, exp_pred);
    else                  chk("R3 forward disabled", pred_taken_o, exp_pred);
    chk("R5 busy pending", busy_o, 1);
    @(negedge clk_i);
    br_valid_i = 1'b0;
    chk("R9 no accept while pending", pred_valid_o, 0);
    chk("R9 pred held", pred_taken_o, exp_pred);
    chk("R5 pred held", busy_o, 1);
    res_valid_i = 1'b1; res_taken_i = taken;
    @(negedge clk_i);
    res_valid_i = 1'b0;
    chk(mis ? "R7 done" : "R6 done", done_o, 1);
    chk(mis ? "R7 redirect" : "R6 redirect", redirect_o, mis);
    chk(mis ? "R7 cost" : "R6 cost", cost_o, mis ? 5 : 1);
    if (!mis) begin
      chk("R6 busy clear", busy_o, 0);
    end else begin
      br_valid_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
        chk("R8 busy stall", busy_o, 1);
        if (k > 0) chk("R9 no accept in stall", pred_valid_o, 0);
        if (k == 1) chk("R7 redirect one cycle", redirect_o, 0);
        @(negedge clk_i);
      end
      br_valid_i = 1'b0;
      chk("R8 busy released", busy_o, 0);
      chk("R9 pred unchanged", pred_taken_o, exp_pred);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 busy", busy_o, 0);
    chk("R10 pred_valid", pred_valid_o, 0);
    chk("R10 pred_taken", pred_taken_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 redirect", redirect_o, 0);
    chk("R10 cost", cost_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b1; res_taken_i = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b0;
    chk("R11 idle resolve ignored", done_o, 0);
    chk("R11 no redirect", redirect_o, 0);
    for (int dc = 0; dc < 3; dc++)
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 2; t++)
          run_branch(dc, e[0], t[0]);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule